// File: doc/BRIEF.md
# Frame-Pixel-Count Video Timing Engine

This block generates the sync, data-enable and pixel-position signals for one display port. A single free-running counter walks every pixel clock of the frame, and all vertical quantities (sync length, frame length, top and bottom of the visible region) are programmed as absolute pixel indices within that frame. A second counter gives the position inside the current line, and it drives the horizontal sync and the horizontal window. Rows are never counted in the timing logic.

Software programs the timing through a simple write port. Every timing field goes into a shadow copy. The working copy is refreshed only when a frame ends, or on every cycle while the engine is stopped. The run/stop bit follows the same rule, so a frame that has started always finishes with the settings it began with. Inside the visible window the engine passes the upstream pixel through when that pixel is valid, and substitutes a programmable underflow colour when it is not. Outside the window it drives a programmable border colour. It also keeps a line counter and a frame counter. For split displays, a slave engine can be set to take its run decision from a master engine's running flag, so both engines start on the same cycle.

Top module: `pct_tgen`

## Requirements
- R1: Writes (`cfg_we` high at a clock edge) go to a shadow register chosen by `cfg_addr`. The address map is:
  - 0: line period in bits [11:0] and hsync width in bits [27:16]
  - 1: frame period
  - 2: vsync length
  - 3: horizontal window, first pixel in [11:0] and last pixel in [27:16]
  - 4: first visible frame index
  - 5: last visible frame index
  - 6: polarity, bit0 hsync and bit1 vsync
  - 7: underflow colour
  - 8: border colour
  - 9: run bit0
  - 10: counter enables
  - 11: follow-master bit0

  A timing write made mid-frame changes nothing until the next frame begins.
- R2: While running, hsync is active while `hpos` is below the programmed width. `hpos` counts 0 up to line period − 1 and then wraps.
- R3: While running, vsync is active while `fpos` is below the programmed vsync length. `fpos` counts 0 up to frame period − 1 and then wraps. A frame wrap also resets `hpos` to 0.
- R4: `de` is high exactly when `fpos` lies in the inclusive vertical range and `hpos` lies in the inclusive horizontal range.
- R5: Polarity bit0 set makes hsync active-low and bit1 set makes vsync active-low. Both bits reset to 0, which means active-high.
- R6: With `de` high, `pix_out` is `pix_in` when `pix_valid` is high and the underflow colour otherwise. With `de` low, `pix_out` is the border colour. The underflow colour resets to 0xFF and the border colour resets to 0.
- R7: A change of the run bit, to either 0 or 1, takes effect only at the end of the current frame. A stopped engine starts on the edge after the new run value is written, at `fpos` 0.
- R8: In the counter-enable field, bit0 enables the 32-bit frame counter, which increments at each frame wrap. Bit1 enables the line counter, which increments at each line wrap. The line counter clears at each frame wrap, and the clear takes precedence over the increment.
- R9: With follow-master set, the engine's run decision comes from `mst_run_i` and its own run bit is ignored.
- R10: While stopped, `run_o`, `de`, `hpos`, `fpos` and `line_cnt` are 0, and both syncs sit at their inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cfg_we | input | 1 | register write strobe |
| cfg_addr | input | 4 | register address |
| cfg_wdata | input | 32 | register write data |
| mst_run_i | input | 1 | running flag of the master engine |
| pix_valid | input | 1 | upstream pixel is available |
| pix_in | input | 24 | upstream pixel colour |
| hsync | output | 1 | horizontal sync with polarity applied |
| vsync | output | 1 | vertical sync with polarity applied |
| de | output | 1 | data enable |
| pix_out | output | 24 | pixel to the port |
| hpos | output | 12 | position within the line |
| fpos | output | 24 | pixel index within the frame |
| line_cnt | output | 16 | line counter |
| frame_cnt | output | 32 | frame counter |
| run_o | output | 1 | engine is running, for slave engines |

## Verification
On the last pixel of a frame, the line-period wrap and the frame wrap happen in the same cycle. The line counter is asked to increment and to clear at once. The bench runs frames whose period is an exact multiple of the line period, so every frame end is also a line end. It then checks that the first pixel of the next frame reads line 0 and an incremented frame count. A second collision comes from register writes made in the middle of a frame, which then compete with the boundary copy. The bench writes polarity and window values partway through a frame and expects the old behaviour up to the last pixel and the new behaviour from the first pixel of the next frame.

// File: rtl/pct_pkg.sv
package pct_pkg;
  typedef enum logic [3:0] {
    A_HSYNC  = 4'd0,
    A_VPER   = 4'd1,
    A_VLEN   = 4'd2,
    A_HWIN   = 4'd3,
    A_VFIRST = 4'd4,
    A_VLAST  = 4'd5,
    A_POL    = 4'd6,
    A_UFLOW  = 4'd7,
    A_BORDER = 4'd8,
    A_RUN    = 4'd9,
    A_CNTEN  = 4'd10,
    A_FOLLOW = 4'd11
  } cfg_addr_e;

  localparam int HI_LSB = 16;
  localparam logic [23:0] UFLOW_RST = 24'h0000FF;
endpackage

// File: rtl/pct_regs.sv
module pct_regs
  import pct_pkg::*;
#(
  parameter int HCW = 12,
  parameter int FCW = 24,
  parameter int PXW = 24,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [3:0]     addr,
  input  logic [DW-1:0]  wdata,
  input  logic           load,
  output logic [HCW-1:0] hper_a,
  output logic [HCW-1:0] hpw_a,
  output logic [FCW-1:0] vper_a,
  output logic [FCW-1:0] vlen_a,
  output logic [HCW-1:0] hfirst_a,
  output logic [HCW-1:0] hlast_a,
  output logic [FCW-1:0] vfirst_a,
  output logic [FCW-1:0] vlast_a,
  output logic [1:0]     pol_a,
  output logic [PXW-1:0] uflow_a,
  output logic [PXW-1:0] border_a,
  output logic           run_sh,
  output logic [1:0]     cnt_en,
  output logic           follow
);
  localparam int HHI = HI_LSB + HCW - 1;

  logic [HCW-1:0] hper_s, hpw_s, hfirst_s, hlast_s;
  logic [FCW-1:0] vper_s, vlen_s, vfirst_s, vlast_s;
  logic [1:0]     pol_s;
  logic [PXW-1:0] uflow_s, border_s;

  function automatic logic hit(input logic w, input logic [3:0] a, input cfg_addr_e t);
    return w && (a == t);
  endfunction

  // shadow set: one clock enable per register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hper_s <= '0; hpw_s <= '0; vper_s <= '0; vlen_s <= '0;
      hfirst_s <= '0; hlast_s <= '0; vfirst_s <= '0; vlast_s <= '0;
      pol_s <= '0; uflow_s <= PXW'(UFLOW_RST); border_s <= '0;
      run_sh <= 1'b0; cnt_en <= '0; follow <= 1'b0;
    end else begin
      if (hit(we, addr, A_HSYNC)) begin
        hper_s <= wdata[HCW-1:0];
        hpw_s  <= wdata[HHI:HI_LSB];
      end
      if (hit(we, addr, A_VPER))   vper_s   <= wdata[FCW-1:0];
      if (hit(we, addr, A_VLEN))   vlen_s   <= wdata[FCW-1:0];
      if (hit(we, addr, A_HWIN)) begin
        hfirst_s <= wdata[HCW-1:0];
        hlast_s  <= wdata[HHI:HI_LSB];
      end
      if (hit(we, addr, A_VFIRST)) vfirst_s <= wdata[FCW-1:0];
      if (hit(we, addr, A_VLAST))  vlast_s  <= wdata[FCW-1:0];
      if (hit(we, addr, A_POL))    pol_s    <= wdata[1:0];
      if (hit(we, addr, A_UFLOW))  uflow_s  <= wdata[PXW-1:0];
      if (hit(we, addr, A_BORDER)) border_s <= wdata[PXW-1:0];
      if (hit(we, addr, A_RUN))    run_sh   <= wdata[0];
      if (hit(we, addr, A_CNTEN))  cnt_en   <= wdata[1:0];
      if (hit(we, addr, A_FOLLOW)) follow   <= wdata[0];
    end
  end

  // working set: copied at the frame boundary or while stopped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hper_a <= '0; hpw_a <= '0; vper_a <= '0; vlen_a <= '0;
      hfirst_a <= '0; hlast_a <= '0; vfirst_a <= '0; vlast_a <= '0;
      pol_a <= '0; uflow_a <= PXW'(UFLOW_RST); border_a <= '0;
    end else if (load) begin
      hper_a <= hper_s; hpw_a <= hpw_s; vper_a <= vper_s; vlen_a <= vlen_s;
      hfirst_a <= hfirst_s; hlast_a <= hlast_s;
      vfirst_a <= vfirst_s; vlast_a <= vlast_s;
      pol_a <= pol_s; uflow_a <= uflow_s; border_a <= border_s;
    end
  end
endmodule

// File: rtl/pct_ctrl.sv
module pct_ctrl #(
  parameter int HCW = 12,
  parameter int FCW = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_req,
  input  logic [HCW-1:0] hper_a,
  input  logic [FCW-1:0] vper_a,
  output logic           run,
  output logic [HCW-1:0] hpos,
  output logic [FCW-1:0] fpos,
  output logic           line_wrap,
  output logic           frame_end,
  output logic           load
);
  logic           run_n;
  logic [HCW-1:0] hpos_n;
  logic [FCW-1:0] fpos_n;

  assign frame_end = run && (fpos == vper_a - 1'b1);
  assign line_wrap = run && (hpos == hper_a - 1'b1);
  assign load      = !run || frame_end;

  always_comb begin
    run_n  = run;
    hpos_n = hpos;
    fpos_n = fpos;
    if (load) begin
      run_n  = run_req;
      hpos_n = '0;
      fpos_n = '0;
    end else begin
      fpos_n = fpos + 1'b1;
      hpos_n = line_wrap ? '0 : hpos + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      hpos <= '0;
      fpos <= '0;
    end else begin
      run  <= run_n;
      hpos <= hpos_n;
      fpos <= fpos_n;
    end
  end
endmodule

// File: rtl/pct_win.sv
module pct_win #(
  parameter int HCW = 12,
  parameter int FCW = 24,
  parameter int PXW = 24
) (
  input  logic           run,
  input  logic [HCW-1:0] hpos,
  input  logic [FCW-1:0] fpos,
  input  logic [HCW-1:0] hpw_a,
  input  logic [FCW-1:0] vlen_a,
  input  logic [HCW-1:0] hfirst_a,
  input  logic [HCW-1:0] hlast_a,
  input  logic [FCW-1:0] vfirst_a,
  input  logic [FCW-1:0] vlast_a,
  input  logic [1:0]     pol_a,
  input  logic [PXW-1:0] uflow_a,
  input  logic [PXW-1:0] border_a,
  input  logic           pix_valid,
  input  logic [PXW-1:0] pix_in,
  output logic           hsync,
  output logic           vsync,
  output logic           de,
  output logic [PXW-1:0] pix_out
);
  logic hs_act, vs_act, in_h, in_v;

  always_comb begin
    hs_act = run && (hpos < hpw_a);
    vs_act = run && (fpos < vlen_a);
    in_h   = (hpos >= hfirst_a) && (hpos <= hlast_a);
    in_v   = (fpos >= vfirst_a) && (fpos <= vlast_a);
    de     = run && in_h && in_v;
    hsync  = hs_act ^ pol_a[0];
    vsync  = vs_act ^ pol_a[1];
    if (!de)            pix_out = border_a;
    else if (pix_valid) pix_out = pix_in;
    else                pix_out = uflow_a;
  end
endmodule

// File: rtl/pct_stats.sv
module pct_stats #(
  parameter int LNW = 16,
  parameter int FRW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           line_wrap,
  input  logic           frame_end,
  input  logic [1:0]     cnt_en,
  output logic [LNW-1:0] line_cnt,
  output logic [FRW-1:0] frame_cnt
);
  logic [LNW-1:0] line_n;
  logic [FRW-1:0] frame_n;

  always_comb begin
    line_n  = line_cnt;
    frame_n = frame_cnt;
    if (frame_end) begin
      line_n = '0;
      if (cnt_en[0]) frame_n = frame_cnt + 1'b1;
    end else if (!run) begin
      line_n = '0;
    end else if (line_wrap && cnt_en[1]) begin
      line_n = line_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_cnt  <= '0;
      frame_cnt <= '0;
    end else begin
      line_cnt  <= line_n;
      frame_cnt <= frame_n;
    end
  end
endmodule

// File: rtl/pct_tgen.sv
module pct_tgen #(
  parameter int HCW = 12,
  parameter int FCW = 24,
  parameter int PXW = 24,
  parameter int LNW = 16,
  parameter int FRW = 32,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [3:0]     cfg_addr,
  input  logic [DW-1:0]  cfg_wdata,
  input  logic           mst_run_i,
  input  logic           pix_valid,
  input  logic [PXW-1:0] pix_in,
  output logic           hsync,
  output logic           vsync,
  output logic           de,
  output logic [PXW-1:0] pix_out,
  output logic [HCW-1:0] hpos,
  output logic [FCW-1:0] fpos,
  output logic [LNW-1:0] line_cnt,
  output logic [FRW-1:0] frame_cnt,
  output logic           run_o
);
  logic [HCW-1:0] hper_a, hpw_a, hfirst_a, hlast_a;
  logic [FCW-1:0] vper_a, vlen_a, vfirst_a, vlast_a;
  logic [1:0]     pol_a, cnt_en;
  logic [PXW-1:0] uflow_a, border_a;
  logic           run_sh, follow, run_req, line_wrap, frame_end, load;

  assign run_req = follow ? mst_run_i : run_sh;

  pct_regs #(.HCW(HCW), .FCW(FCW), .PXW(PXW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .load(load), .hper_a(hper_a), .hpw_a(hpw_a), .vper_a(vper_a),
    .vlen_a(vlen_a), .hfirst_a(hfirst_a), .hlast_a(hlast_a),
    .vfirst_a(vfirst_a), .vlast_a(vlast_a), .pol_a(pol_a),
    .uflow_a(uflow_a), .border_a(border_a), .run_sh(run_sh),
    .cnt_en(cnt_en), .follow(follow)
  );

  pct_ctrl #(.HCW(HCW), .FCW(FCW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .run_req(run_req), .hper_a(hper_a),
    .vper_a(vper_a), .run(run_o), .hpos(hpos), .fpos(fpos),
    .line_wrap(line_wrap), .frame_end(frame_end), .load(load)
  );

  pct_win #(.HCW(HCW), .FCW(FCW), .PXW(PXW)) u_win (
    .run(run_o), .hpos(hpos), .fpos(fpos), .hpw_a(hpw_a), .vlen_a(vlen_a),
    .hfirst_a(hfirst_a), .hlast_a(hlast_a), .vfirst_a(vfirst_a),
    .vlast_a(vlast_a), .pol_a(pol_a), .uflow_a(uflow_a),
    .border_a(border_a), .pix_valid(pix_valid), .pix_in(pix_in),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_out(pix_out)
  );

  pct_stats #(.LNW(LNW), .FRW(FRW)) u_stats (
    .clk(clk), .rst_n(rst_n), .run(run_o), .line_wrap(line_wrap),
    .frame_end(frame_end), .cnt_en(cnt_en), .line_cnt(line_cnt),
    .frame_cnt(frame_cnt)
  );
endmodule

// File: rtl/pct_chk.sv
module pct_chk #(
  parameter int HCW = 12,
  parameter int FCW = 24,
  parameter int PXW = 24,
  parameter int LNW = 16,
  parameter int FRW = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           run,
  input logic [HCW-1:0] hpos,
  input logic [FCW-1:0] fpos,
  input logic [HCW-1:0] hpw_a,
  input logic [FCW-1:0] vper_a,
  input logic [1:0]     pol_a,
  input logic [1:0]     cnt_en,
  input logic [PXW-1:0] uflow_a,
  input logic           hsync,
  input logic           de,
  input logic           pix_valid,
  input logic [PXW-1:0] pix_out,
  input logic [LNW-1:0] line_cnt,
  input logic [FRW-1:0] frame_cnt
);
  logic last_px;
  assign last_px = run && (fpos == vper_a - 1'b1);

  p_shadow_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !last_px) |=> $stable(vper_a));

  p_hsync_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hpos < hpw_a) |-> (hsync != pol_a[0]));

  p_fpos_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && vper_a != '0) |-> (fpos < vper_a));

  p_uflow_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (de && !pix_valid) |-> (pix_out == uflow_a));

  p_run_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !last_px) |=> run);

  p_line_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last_px |=> (line_cnt == '0));

  p_frame_inc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (last_px && cnt_en[0]) |=> (frame_cnt == $past(frame_cnt) + 1'b1));

  p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!de && hpos == '0 && fpos == '0));
endmodule

bind pct_tgen pct_chk #(.HCW(HCW), .FCW(FCW), .PXW(PXW), .LNW(LNW), .FRW(FRW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run_o), .hpos(hpos), .fpos(fpos),
  .hpw_a(hpw_a), .vper_a(vper_a), .pol_a(pol_a), .cnt_en(cnt_en),
  .uflow_a(uflow_a), .hsync(hsync), .de(de), .pix_valid(pix_valid),
  .pix_out(pix_out), .line_cnt(line_cnt), .frame_cnt(frame_cnt)
);

// File: tb/sim_pct_tgen.sv
`timescale 1ns/1ps
module sim_pct_tgen;
  localparam int HT = 10, PW = 2, VP = 60, VL = 20, VF = 30, VLS = 49;
  localparam logic [23:0] PIN = 24'hABCDEF, BRD = 24'h000123;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, mst_run_i = 1'b0, pix_valid = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [23:0] pix_in = PIN;
  logic hsync, vsync, de, run_o;
  logic [23:0] pix_out, fpos;
  logic [11:0] hpos;
  logic [15:0] line_cnt;
  logic [31:0] frame_cnt;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  pct_tgen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .mst_run_i(mst_run_i), .pix_valid(pix_valid),
    .pix_in(pix_in), .hsync(hsync), .vsync(vsync), .de(de), .pix_out(pix_out),
    .hpos(hpos), .fpos(fpos), .line_cnt(line_cnt), .frame_cnt(frame_cnt),
    .run_o(run_o)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic sync_start();
    int guard = 0;
    do begin
      @(negedge clk); #1; guard++;
    end while (!(run_o && fpos == 0) && guard < 500);
    chk("R7 frame start reached", guard < 500, 1);
  endtask

  // expected outputs for running-cycle k of a frame pair
  task automatic expect_cycle(input int k, input bit inv, input int h0, input int h1,
                              input bit pv, input int fc0, input bit cnt_chk);
    int x = k % HT, f = k % VP;
    bit e_de = (f >= VF) && (f <= VLS) && (x >= h0) && (x <= h1);
    chk("R2 hpos", hpos, x);
    chk("R3 fpos", fpos, f);
    chk("R2 R5 hsync", hsync, (x < PW) ^ inv);
    chk("R3 R5 vsync", vsync, (f < VL) ^ inv);
    chk("R4 de", de, e_de);
    chk("R6 pix_out", pix_out, e_de ? (pv ? PIN : 24'hFF) : BRD);
    if (cnt_chk) begin
      chk("R8 line_cnt", line_cnt, f / HT);
      chk("R8 frame_cnt", frame_cnt, fc0 + k / VP);
    end
  endtask

  task automatic t_reset();
    #1;
    chk("R10 run after reset", run_o, 0);
    chk("R10 hsync after reset", hsync, 0);
    chk("R10 vsync after reset", vsync, 0);
    chk("R10 de after reset", de, 0);
    chk("R6 border reset 0", pix_out, 0);
    chk("R10 fpos after reset", fpos, 0);
    chk("R8 frame_cnt reset", frame_cnt, 0);
  endtask

  task automatic t_main();
    wr(4'd0, 32'(HT) | (32'(PW) << 16));
    wr(4'd1, VP); wr(4'd2, VL);
    wr(4'd3, 32'd3 | (32'd8 << 16));
    wr(4'd4, VF); wr(4'd5, VLS);
    wr(4'd8, BRD); wr(4'd10, 3);
    wr(4'd9, 1);
    sync_start();
    for (int k = 0; k < 2 * VP + 1; k++) begin
      if (k > 0) @(negedge clk);
      pix_valid = (k % 3) != 0;
      #1;
      expect_cycle(k, 1'b0, 3, 8, pix_valid, 0, 1'b1);
    end
  endtask

  task automatic t_shadow();
    int fc0;
    sync_start();
    fc0 = frame_cnt;
    for (int k = 0; k < 2 * VP; k++) begin
      if (k > 0) @(negedge clk);
      pix_valid = 1'b1;
      cfg_we = 1'b0;
      if (k == 5) begin cfg_we = 1'b1; cfg_addr = 4'd6; cfg_wdata = 3; end
      if (k == 7) begin cfg_we = 1'b1; cfg_addr = 4'd3; cfg_wdata = 32'd0 | (32'd9 << 16); end
      #1;
      // R1 R5: mid-frame writes apply only from the next frame
      if (k < VP) expect_cycle(k, 1'b0, 3, 8, 1'b1, fc0, 1'b1);
      else        expect_cycle(k, 1'b1, 0, 9, 1'b1, fc0, 1'b1);
    end
    cfg_we = 1'b0;
    wr(4'd6, 0);
    wr(4'd3, 32'd3 | (32'd8 << 16));
  endtask

  task automatic t_stop();
    int fc0;
    sync_start();
    fc0 = frame_cnt;
    for (int k = 0; k < VP + 6; k++) begin
      if (k > 0) @(negedge clk);
      cfg_we = (k == 10);
      cfg_addr = 4'd9; cfg_wdata = 0;
      #1;
      if (k < VP) begin
        chk("R7 run holds to frame end", run_o, 1);
        expect_cycle(k, 1'b0, 3, 8, 1'b1, fc0, 1'b1);
      end else begin
        chk("R7 stopped at boundary", run_o, 0);
        chk("R10 hsync idle", hsync, 0);
        chk("R10 vsync idle", vsync, 0);
        chk("R10 de idle", de, 0);
        chk("R10 fpos idle", fpos, 0);
        chk("R10 line_cnt idle", line_cnt, 0);
        chk("R6 border when idle", pix_out, BRD);
        chk("R8 last frame counted", frame_cnt, fc0 + 1);
      end
    end
    cfg_we = 1'b0;
  endtask

  task automatic t_cnten();
    int fc0;
    wr(4'd10, 1);
    wr(4'd9, 1);
    sync_start();
    fc0 = frame_cnt;
    for (int k = 0; k <= VP; k++) begin
      if (k > 0) @(negedge clk);
      #1;
      chk("R8 line counter disabled", line_cnt, 0);
      chk("R8 frame counter enabled", frame_cnt, fc0 + k / VP);
    end
    wr(4'd9, 0);
  endtask

  task automatic t_master();
    int guard = 0;
    do begin @(negedge clk); #1; guard++; end while (run_o && guard < 500);
    chk("R7 stopped before follow test", run_o, 0);
    wr(4'd11, 1);
    wr(4'd9, 1);
    for (int i = 0; i < 70; i++) begin
      @(negedge clk); #1;
      chk("R9 own run bit ignored", run_o, 0);
    end
    @(negedge clk); mst_run_i = 1'b1;
    @(negedge clk); #1;
    chk("R9 starts with master", run_o, 1);
    chk("R9 starts at frame index 0", fpos, 0);
    for (int k = 1; k <= VP; k++) begin
      @(negedge clk);
      if (k == 20) mst_run_i = 1'b0;
      #1;
      chk("R9 R7 follow stop at boundary", run_o, k < VP);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_main();
    t_shadow();
    t_stop();
    t_cnten();
    t_master();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule